// File: doc/BRIEF.md
# Pulse-Skipping Overcurrent Limiter

This block gates the switch drive of a fixed-frequency PWM power stage so that an overload cannot build up current without bound. A strobe marks the start of each switching period. Inside a period the drive follows the PWM on-request. For the first few clocks of on-time the overcurrent comparator is ignored, because switching noise makes it unreliable there. At the first clock after that blanking window the comparator is sampled exactly once.

A sample that shows overcurrent cuts the drive in that same clock and keeps it off until the period ends. It also raises an adaptive skip level by one, up to a cap, and that many following periods are then held dark. A sample that shows no overcurrent lowers the level by one. Under a sustained overload the level rises to the cap. From then on the switch fires in one period out of cap+1, which with the default cap of seven is one eighth of the nominal rate. The comparator and the current sensing are outside the block.

Top module: `ocp_skip_limiter`

## Requirements
- R1: After reset, skip_level is 0 and oc_active is 0. In a period that is not skipped and has no fault, drive equals pwm_req.
- R2: The first BLANK_CYCLES clocks of on-time in a period are the blanking window. During this window oc_cmp has no effect on drive, skip_level or oc_active. On-time counts clocks in which pwm_req is high and the period is neither skipped nor cut off.
- R3: The comparator is sampled once per period, at the first on-time clock after blanking. If oc_cmp is high in that clock, drive is low in that clock and in every later clock of the period, and oc_active is high for the same span. oc_cmp after the sample has no effect.
- R4: A sample that shows overcurrent raises skip_level by one from the next clock. The same number of following periods is then skipped.
- R5: skip_level saturates at MAX_SKIP (default 7). The count of periods still pending a skip never exceeds skip_level.
- R6: A sample that shows no overcurrent lowers skip_level by one, with 0 as the floor, and schedules no skip.
- R7: In a skipped period, drive is low and oc_active is high for the whole period, whatever pwm_req is. oc_cmp is not sampled, and skip_level does not change.
- R8: If pwm_req ends before the blanking window is over, the period takes no sample and skip_level is unchanged.
- R9: Under a sustained fault at saturation, drive is active in exactly one of every MAX_SKIP+1 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | One-clock strobe in the first clock of each switching period |
| pwm_req | input | 1 | On-request from the PWM modulator |
| oc_cmp | input | 1 | Overcurrent comparator output, high when the current is over the limit |
| drive | output | 1 | Gated power switch drive |
| skip_level | output | $clog2(MAX_SKIP+1) (3) | Current adaptive skip level |
| oc_active | output | 1 | High while the limiter suppresses drive: the current period is cut off or skipped |

## Verification
The bench sweeps every on-time length together with every combination of comparator state during blanking, at the sample point and after it. A design that samples one clock early or late, or that samples again after the sample point, would cut the drive in the wrong clock. The bench also drives the level to the cap and counts the active periods. An increment that wraps instead of saturating would show up there as a skip level of 0 and far too many active periods. Short on-times that end inside the blanking window, and noise during skipped periods, catch a design that lets an unsampled or skipped period move the level.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  // saturating step up of the skip level
  function automatic int sat_up(input int v, input int cap);
    return (v >= cap) ? cap : v + 1;
  endfunction

  // step down with a floor of zero
  function automatic int sat_down(input int v);
    return (v > 0) ? v - 1 : 0;
  endfunction
endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int BLANK_CYCLES = 50,
  parameter int BW = $clog2(BLANK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  output logic fire
);
  localparam logic [BW-1:0] LIMIT = BW'(BLANK_CYCLES);

  logic [BW-1:0] cnt_q, cnt_now;
  logic          done_q, done_now;

  initial assert (BLANK_CYCLES >= 1);

  always_comb begin
    cnt_now  = restart ? '0 : cnt_q;
    done_now = restart ? 1'b0 : done_q;
    fire     = en & ~done_now & (cnt_now == LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_now | fire;
      if (en && !done_now && cnt_now != LIMIT) cnt_q <= cnt_now + BW'(1);
      else                                     cnt_q <= cnt_now;
    end
  end

  // R3: one sample per period
  p_single_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/ocp_skip_ctrl.sv
module ocp_skip_ctrl #(
  parameter int MAX_SKIP = 7,
  parameter int CW = $clog2(MAX_SKIP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cycle_start,
  input  logic          sample,
  input  logic          oc,
  output logic          skip_now,
  output logic          trip_now,
  output logic [CW-1:0] level
);
  import ocp_pkg::*;

  logic [CW-1:0] level_q, pend_q;
  logic          skipped_q, tripped_q;
  logic [CW-1:0] level_up, level_dn;

  always_comb begin
    skip_now = cycle_start ? (pend_q != '0) : skipped_q;
    trip_now = cycle_start ? 1'b0 : tripped_q;
    level_up = CW'(sat_up(int'(level_q), MAX_SKIP));
    level_dn = CW'(sat_down(int'(level_q)));
  end

  assign level = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q   <= '0;
      pend_q    <= '0;
      skipped_q <= 1'b0;
      tripped_q <= 1'b0;
    end else begin
      if (cycle_start) begin
        skipped_q <= (pend_q != '0);
        tripped_q <= 1'b0;
        if (pend_q != '0) pend_q <= pend_q - CW'(1);
      end
      if (sample) begin
        if (oc) begin
          level_q   <= level_up;
          pend_q    <= level_up;
          tripped_q <= 1'b1;
        end else begin
          level_q   <= level_dn;
        end
      end
    end
  end

  // R4: a fault below the cap raises the level by one
  p_level_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && oc && int'(level_q) < MAX_SKIP) |=> int'(level_q) == int'($past(level_q)) + 1);
  // R6: a clean sample lowers a nonzero level by one
  p_level_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !oc && level_q != '0) |=> int'(level_q) + 1 == int'($past(level_q)));
  // R5: level moves by at most one per clock and never passes the cap
  p_level_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level_q) - int'($past(level_q))) inside {-1, 0, 1});
  p_pend_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= level_q && int'(level_q) <= MAX_SKIP);
endmodule

// File: rtl/ocp_skip_limiter.sv
module ocp_skip_limiter #(
  parameter int BLANK_CYCLES = 50,
  parameter int MAX_SKIP = 7,
  parameter int LVL_W = $clog2(MAX_SKIP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_start,
  input  logic             pwm_req,
  input  logic             oc_cmp,
  output logic             drive,
  output logic [LVL_W-1:0] skip_level,
  output logic             oc_active
);
  logic skip_now, trip_now, on_elig, sample_fire, oc_kill;

  ocp_skip_ctrl #(.MAX_SKIP(MAX_SKIP), .CW(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .sample(sample_fire), .oc(oc_cmp),
    .skip_now(skip_now), .trip_now(trip_now), .level(skip_level)
  );

  ocp_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk(clk), .rst_n(rst_n), .restart(cycle_start),
    .en(on_elig), .fire(sample_fire)
  );

  always_comb begin
    on_elig   = pwm_req & ~skip_now & ~trip_now;
    oc_kill   = sample_fire & oc_cmp;
    drive     = on_elig & ~oc_kill;
    oc_active = skip_now | trip_now | oc_kill;
  end

  // R3: once cut off, drive stays low until the next period
  p_cutoff_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oc_kill |=> (cycle_start || !drive));
  // R7: a skipped period neither drives nor samples
  p_skip_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_now |-> (!drive && !sample_fire && oc_active));
endmodule

// File: tb/ocp_skip_limiter_tb.sv
`timescale 1ns/1ps
module ocp_skip_limiter_tb_top;
  localparam int B = 3;
  localparam int MAXS = 7;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_start = 1'b0, pwm_req = 1'b0, oc_cmp = 1'b0;
  logic drive, oc_active;
  logic [2:0] skip_level;

  int n_chk = 0, n_fail = 0;
  int m_level = 0, m_pend = 0;
  bit period_drove;

  always #2 clk = ~clk;

  ocp_skip_limiter #(.BLANK_CYCLES(B), .MAX_SKIP(MAXS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .pwm_req(pwm_req),
    .oc_cmp(oc_cmp), .drive(drive), .skip_level(skip_level), .oc_active(oc_active)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic run_period(input int on_len, input bit noise, input bit samp_oc,
                            input bit late_oc, input string tag);
    bit m_skip = 0, m_trip = 0, m_done = 0, pd = 0;
    int oncnt = 0;
    for (int k = 0; k < P; k++) begin
      bit elig, smp, kill, e_drv, e_act;
      string t;
      @(negedge clk);
      cycle_start = (k == 0);
      pwm_req = (k < on_len);
      oc_cmp = (k < B) ? noise : ((k == B) ? samp_oc : late_oc);
      if (k == 0) begin
        m_skip = (m_pend != 0);
        if (m_skip) m_pend--;
      end
      elig = pwm_req && !m_skip && !m_trip;
      smp = elig && !m_done && oncnt == B;
      kill = smp && oc_cmp;
      e_drv = elig && !kill;
      e_act = m_skip || m_trip || kill;
      t = m_skip ? "R7" : ((kill || m_trip) ? "R3" : tag);
      #1;
      chk(drive == e_drv, t, "drive", int'(drive), int'(e_drv));
      chk(oc_active == e_act, t, "oc_active", int'(oc_active), int'(e_act));
      chk(int'(skip_level) == m_level, t, "skip_level", int'(skip_level), m_level);
      if (drive) pd = 1;
      if (smp) begin
        m_done = 1;
        if (oc_cmp) begin
          m_level = (m_level < MAXS) ? m_level + 1 : MAXS;
          m_pend = m_level;
          m_trip = 1;
        end else if (m_level > 0) m_level--;
      end else if (elig && !m_done) oncnt++;
    end
    period_drove = pd;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int drove;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; pwm_req = 1'b1;
    #1;
    // R1 reset state
    chk(skip_level == 3'd0, "R1", "reset skip_level", int'(skip_level), 0);
    chk(oc_active == 1'b0, "R1", "reset oc_active", int'(oc_active), 0);
    chk(drive == 1'b1, "R1", "reset drive follows pwm", int'(drive), 1);

    // R1/R2: clean periods with blanking noise
    run_period(P, 1, 0, 0, "R2");
    run_period(6, 1, 0, 1, "R3");
    // R4: single fault from level 0
    run_period(P, 0, 1, 0, "R4");
    @(negedge clk); #1;
    chk(skip_level == 3'd1, "R4", "level after first fault", int'(skip_level), 1);
    run_period(P, 1, 1, 1, "R7");
    run_period(P, 0, 0, 0, "R6");

    // R8: short on-time leaves level alone
    run_period(P, 0, 1, 0, "R4");
    run_period(P, 0, 0, 0, "R7");
    run_period(B, 1, 1, 1, "R8");
    chk(m_level == 1, "R8", "model level held", m_level, 1);
    @(negedge clk); #1;
    chk(skip_level == 3'd1, "R8", "level after short on-time", int'(skip_level), 1);

    // R5: sustained fault drives level to the cap
    for (int i = 0; i < 60; i++) run_period(P, 1, 1, 1, "R5");
    while (m_pend != MAXS) run_period(P, 1, 1, 1, "R5");
    chk(int'(skip_level) == MAXS, "R5", "saturated level", int'(skip_level), MAXS);

    // R9: one active period in MAXS+1
    drove = 0;
    for (int i = 0; i < 4 * (MAXS + 1); i++) begin
      run_period(P, 1, 1, 1, "R9");
      if (period_drove) drove++;
    end
    chk(drove == 4, "R9", "active periods in 32", drove, 4);

    // R6: decay back to zero
    for (int i = 0; i < 20; i++) run_period(P, 0, 0, 1, "R6");
    @(negedge clk); #1;
    chk(skip_level == 3'd0, "R6", "level after decay", int'(skip_level), 0);

    // R2: sweep on-time length against comparator patterns
    for (int len = 0; len <= P; len++)
      for (int pat = 0; pat < 8; pat++)
        run_period(len, pat[0], pat[1], pat[2], "R2");
    for (int i = 0; i < 10; i++) run_period(P, 0, 0, 0, "R6");

    finish_run();
  end
endmodule